// File: doc/BRIEF.md
# Forwarding Write Buffer

This block sits between a write-through cache and main memory. The processor hands it stores, and each store is queued in a small circular buffer so the processor moves on at once instead of waiting for memory. The buffer sends the queued stores to memory one at a time, oldest first, over a valid/ready write port.

Before a read that missed in the cache goes out to memory, its address is presented on the lookup port. That address is compared against every queued entry in parallel. If an entry matches, memory still holds a stale value for that address. In the default forwarding variant, the newest matching store's data is returned in the same cycle as the lookup. In the alternative stall variant, a match raises a stall flag so the read waits until the buffer has drained. A read that matches nothing is flagged as a miss so it can proceed to memory.

Top module: `wbuf_fwd`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1 and `mem_valid` is 0.
- R2: While the buffer holds fewer than DEPTH entries, `st_ready` is 1, and a store presented with `st_valid` is queued at that clock edge.
- R3: With DEPTH entries held, `st_ready` is 0. A store offered in that state is ignored: it never reaches memory and is never visible to lookups.
- R4: `mem_valid` is 1 whenever the buffer holds an entry. `mem_addr`/`mem_data` show the oldest entry and stay unchanged until `mem_ready` is seen. Entries leave one per handshake in the order they were queued.
- R5: A store accepted in the same cycle as a memory handshake leaves the occupancy unchanged.
- R6: In forwarding mode, a lookup whose address matches a queued entry raises `rd_hit` and returns that entry's data on `rd_data` in the same cycle, with `rd_miss` at 0.
- R7: When several queued entries match the lookup address, `rd_data` carries the data of the most recently queued one.
- R8: A lookup matching no queued entry raises `rd_miss` with `rd_hit` and `rd_stall` at 0. Entries that have already been written to memory no longer match.
- R9: In stall mode, a matching lookup raises `rd_stall` instead of `rd_hit`, and a non-matching lookup raises `rd_miss`.
- R10: With `rd_valid` at 0, `rd_hit`, `rd_miss` and `rd_stall` are all 0. At most one of the three is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| rd_valid | input | 1 | Lookup request |
| rd_addr | input | ADDR_W | Lookup address |
| rd_hit | output | 1 | Lookup matched, data forwarded |
| rd_miss | output | 1 | Lookup matched nothing |
| rd_stall | output | 1 | Lookup matched, read must wait (stall mode) |
| rd_data | output | DATA_W | Forwarded data of newest match |
| mem_valid | output | 1 | Memory write pending |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |

## Verification
Lookup results are combinational. The bench therefore drives a lookup just after a falling edge and reads `rd_hit`, `rd_miss`, `rd_stall` and `rd_data` one nanosecond later, before any edge. A store affects lookups and `st_ready` from the first falling edge after the rising edge that accepts it, and the bench samples there. A memory write completes at the rising edge that follows a falling edge where `mem_valid` and `mem_ready` are both high. The monitor checks the write at that falling edge, against the head of a queue that the store driver filled with every accepted store.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

   // How a lookup that hits a pending store is resolved
   typedef enum logic {
      HZ_FORWARD = 1'b0,
      HZ_STALL   = 1'b1
   } hazard_mode_e;

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [ADDR_W-1:0]             push_addr,
   input  logic [DATA_W-1:0]             push_data,
   input  logic                          pop,
   output logic [DEPTH-1:0][ADDR_W-1:0]  addr_arr,
   output logic [DEPTH-1:0][DATA_W-1:0]  data_arr,
   output logic [PW-1:0]                 head_ptr,
   output logic [CW-1:0]                 count
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("wbuf_store: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [PW-1:0] tail_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_ptr <= '0;
         tail_ptr <= '0;
         count    <= '0;
      end else begin
         if (push) begin
            tail_ptr <= tail_ptr + PW'(1);
         end
         if (pop) begin
            head_ptr <= head_ptr + PW'(1);
         end
         case ({push, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_arr[tail_ptr] <= push_addr;
         data_arr[tail_ptr] <= push_data;
      end
   end

   // R3: occupancy never exceeds the buffer depth
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R2: a lone push grows occupancy by one
   p_push_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop |=> count == $past(count) + CW'(1));

   // R5: push and pop together keep occupancy
   p_simul_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push && pop |=> count == $past(count));

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic [DEPTH-1:0][ADDR_W-1:0] addr_arr,
   input  logic [DEPTH-1:0][DATA_W-1:0] data_arr,
   input  logic [PW-1:0]                head_ptr,
   input  logic [CW-1:0]                count,
   input  logic [ADDR_W-1:0]            look_addr,
   output logic                         any_hit,
   output logic [DATA_W-1:0]            hit_data
);

   // Walk from oldest to newest; a later match overrides, so the newest wins
   always_comb begin
      any_hit  = 1'b0;
      hit_data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         logic [PW-1:0] idx;
         idx = head_ptr + PW'(k);
         if (CW'(k) < count && addr_arr[idx] == look_addr) begin
            any_hit  = 1'b1;
            hit_data = data_arr[idx];
         end
      end
   end

endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd
   import wbuf_pkg::*;
#(
   parameter int           ADDR_W = 16,
   parameter int           DATA_W = 32,
   parameter int           DEPTH  = 4,
   parameter hazard_mode_e MODE   = HZ_FORWARD,
   localparam int          PW     = $clog2(DEPTH),
   localparam int          CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   output logic              st_ready,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_hit,
   output logic              rd_miss,
   output logic              rd_stall,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data
);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("wbuf_fwd: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic [DEPTH-1:0][ADDR_W-1:0] addr_arr;
   logic [DEPTH-1:0][DATA_W-1:0] data_arr;
   logic [PW-1:0]                head_ptr;
   logic [CW-1:0]                count;
   logic                         any_hit;
   logic [DATA_W-1:0]            hit_data;
   logic                         push;
   logic                         pop;

   assign st_ready  = count != CW'(DEPTH);
   assign mem_valid = count != '0;
   assign push      = st_valid && st_ready;
   assign pop       = mem_valid && mem_ready;
   assign mem_addr  = addr_arr[head_ptr];
   assign mem_data  = data_arr[head_ptr];

   wbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (st_addr),
      .push_data (st_data),
      .pop       (pop),
      .addr_arr  (addr_arr),
      .data_arr  (data_arr),
      .head_ptr  (head_ptr),
      .count     (count)
   );

   wbuf_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_match (
      .addr_arr  (addr_arr),
      .data_arr  (data_arr),
      .head_ptr  (head_ptr),
      .count     (count),
      .look_addr (rd_addr),
      .any_hit   (any_hit),
      .hit_data  (hit_data)
   );

   assign rd_miss = rd_valid && !any_hit;

   generate
      if (MODE == HZ_FORWARD) begin : g_forward
         assign rd_hit   = rd_valid && any_hit;
         assign rd_stall = 1'b0;
         assign rd_data  = (rd_valid && any_hit) ? hit_data : '0;
      end else begin : g_stall
         assign rd_hit   = 1'b0;
         assign rd_stall = rd_valid && any_hit;
         assign rd_data  = '0;
      end
   endgenerate

   // R4: a pending memory write holds still until accepted
   p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

   // R10: lookup responses are mutually exclusive
   p_resp_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_hit, rd_miss, rd_stall}));

   // R10: no response without a lookup
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> !rd_hit && !rd_miss && !rd_stall);

   // R8: an empty buffer can only miss
   p_empty_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !mem_valid |-> rd_miss);

endmodule

// File: tb/wbuf_fwd_tb.sv
`timescale 1ns/100ps
module wbuf_fwd_tb;
   import wbuf_pkg::*;

   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic          rd_valid = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          mem_ready = 1'b0;

   logic          f_st_ready, f_hit, f_miss, f_stall, f_mem_valid;
   logic [DW-1:0] f_rd_data, f_mem_data;
   logic [AW-1:0] f_mem_addr;
   logic          s_st_ready, s_hit, s_miss, s_stall, s_mem_valid;
   logic [DW-1:0] s_rd_data, s_mem_data;
   logic [AW-1:0] s_mem_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [AW+DW-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   wbuf_fwd #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .MODE(HZ_FORWARD)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(f_st_ready), .st_addr(st_addr), .st_data(st_data),
      .rd_valid(rd_valid), .rd_addr(rd_addr),
      .rd_hit(f_hit), .rd_miss(f_miss), .rd_stall(f_stall), .rd_data(f_rd_data),
      .mem_valid(f_mem_valid), .mem_ready(mem_ready),
      .mem_addr(f_mem_addr), .mem_data(f_mem_data));

   wbuf_fwd #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .MODE(HZ_STALL)) u_dut_stall (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(s_st_ready), .st_addr(st_addr), .st_data(st_data),
      .rd_valid(rd_valid), .rd_addr(rd_addr),
      .rd_hit(s_hit), .rd_miss(s_miss), .rd_stall(s_stall), .rd_data(s_rd_data),
      .mem_valid(s_mem_valid), .mem_ready(mem_ready),
      .mem_addr(s_mem_addr), .mem_data(s_mem_data));

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One cycle of stimulus: drive after the falling edge, let it settle
   task automatic cyc(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input bit rv, input logic [AW-1:0] ra, input bit mr);
      @(negedge clk);
      st_valid  = sv;
      st_addr   = sa;
      st_data   = sd;
      rd_valid  = rv;
      rd_addr   = ra;
      mem_ready = mr;
      #1;
      if (sv && f_st_ready) exp_q.push_back({sa, sd});
   endtask

   task automatic idle();
      cyc(1'b0, '0, '0, 1'b0, '0, 1'b0);
   endtask

   task automatic lookup_hit(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
      cyc(1'b0, '0, '0, 1'b1, a, 1'b0);
      check(f_hit && !f_miss && !f_stall, req, "hit flags", {f_hit, f_miss, f_stall}, 3'b100);
      check(f_rd_data == d, req, "forwarded data", f_rd_data, d);
      check(s_stall && !s_hit && !s_miss, "R9", "stall-mode flags", {s_hit, s_miss, s_stall}, 3'b001);
   endtask

   task automatic lookup_miss(input logic [AW-1:0] a, input string req);
      cyc(1'b0, '0, '0, 1'b1, a, 1'b0);
      check(f_miss && !f_hit && !f_stall, req, "miss flags", {f_hit, f_miss, f_stall}, 3'b010);
      check(s_miss && !s_hit && !s_stall, "R9", "stall-mode miss", {s_hit, s_miss, s_stall}, 3'b010);
   endtask

   // Scoreboard monitor: a handshake set up now completes at the next rising edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && f_mem_valid && mem_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4", "unexpected memory write", {f_mem_addr, f_mem_data}, '0);
            end else begin
               logic [AW+DW-1:0] e;
               e = exp_q.pop_front();
               check({f_mem_addr, f_mem_data} == e, "R4", "drain order", {f_mem_addr, f_mem_data}, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(f_st_ready == 1'b1, "R1", "st_ready after reset", f_st_ready, 1);
      check(f_mem_valid == 1'b0, "R1", "mem_valid after reset", f_mem_valid, 0);
      lookup_miss(16'h0010, "R8");

      cyc(1'b0, '0, '0, 1'b0, 16'h0010, 1'b0);
      check(!f_hit && !f_miss && !f_stall && !s_hit && !s_miss && !s_stall, "R10",
            "quiet without lookup", {f_hit, f_miss, f_stall, s_hit, s_miss, s_stall}, 0);

      cyc(1'b1, 16'h0010, 32'h111, 1'b0, '0, 1'b0);
      check(f_st_ready, "R2", "ready when empty", f_st_ready, 1);
      cyc(1'b1, 16'h0020, 32'h222, 1'b0, '0, 1'b0);
      check(f_st_ready, "R2", "ready with one entry", f_st_ready, 1);
      cyc(1'b1, 16'h0010, 32'h333, 1'b0, '0, 1'b0);
      check(f_st_ready, "R2", "ready with two entries", f_st_ready, 1);

      lookup_hit(16'h0010, 32'h333, "R7");
      lookup_hit(16'h0020, 32'h222, "R6");
      check(f_mem_valid && f_mem_addr == 16'h0010 && f_mem_data == 32'h111, "R4",
            "head presented", {f_mem_valid, f_mem_addr, f_mem_data}, {1'b1, 16'h0010, 32'h111});
      lookup_miss(16'h0030, "R8");

      cyc(1'b1, 16'h0040, 32'h444, 1'b0, '0, 1'b0);
      idle();
      check(f_st_ready == 1'b0, "R3", "not ready when full", f_st_ready, 0);
      cyc(1'b1, 16'h0050, 32'h555, 1'b0, '0, 1'b0);
      lookup_miss(16'h0050, "R3");
      check(f_mem_addr == 16'h0010, "R4", "head held without ready", f_mem_addr, 16'h0010);

      cyc(1'b0, '0, '0, 1'b0, '0, 1'b1);
      lookup_hit(16'h0010, 32'h333, "R7");
      check(f_st_ready, "R3", "ready after one drain", f_st_ready, 1);

      cyc(1'b1, 16'h0060, 32'h666, 1'b0, '0, 1'b1);
      idle();
      check(f_st_ready == 1'b1, "R5", "occupancy kept at three", f_st_ready, 1);
      cyc(1'b1, 16'h0070, 32'h777, 1'b0, '0, 1'b0);
      idle();
      check(f_st_ready == 1'b0, "R5", "one more store fills", f_st_ready, 0);
      lookup_miss(16'h0020, "R8");
      lookup_hit(16'h0070, 32'h777, "R6");

      for (int i = 0; i < 6; i++) cyc(1'b0, '0, '0, 1'b0, '0, 1'b1);
      idle();
      check(f_mem_valid == 1'b0, "R4", "empty after drain", f_mem_valid, 0);
      check(exp_q.size() == 0, "R4", "all stores written", exp_q.size(), 0);
      lookup_miss(16'h0010, "R8");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule